// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block is the processor-facing half of an SPI master. It decodes single-cycle 32-bit register reads and writes on a small byte-addressed bus. It stores the configuration word, the clock divider, the FIFO threshold levels and the interrupt enables, and passes them to a separate serial shift engine. It also buffers outgoing and incoming data words in two small FIFOs.

A write to the command offset starts the engine with a one-cycle strobe and a captured copy of the command word. The engine then pops transmit words, pushes receive words and signals completion. Every event from the engine or the FIFOs lands in a sticky status register that software clears by writing ones. A single level interrupt is raised from the enabled status bits.

The bus read data is combinational from the current state. A receive-data read removes the word at the edge that ends the read cycle.

Top module: `spi_regfront`

## Requirements
- R1: After reset, these offsets read zero: configuration (0x00), divider (0x04), interrupt enable (0x10) and word count (0x18). The threshold offset (0x14) reads 0x80. Once clocks run, the status offset (0x0C) reads 0x04 and `irq` is low.
- R2: The configuration register keeps all 32 bits and the divider keeps bits [15:0]. Interrupt enable keeps bits [4:0] and the threshold register keeps bits [7:0]. Higher bits read as zero.
- R3: Each write to 0x1C pushes one word into an 8-deep transmit FIFO, and a write while the FIFO holds 8 words is dropped. The count appears in word-count bits [7:4]. The engine receives words in push order through `eng_tx_data` / `eng_tx_pop`.
- R4: Each `eng_rx_push` stores `eng_rx_data` in an 8-deep receive FIFO, and the count appears in word-count bits [3:0]. Each read of 0x20 returns the oldest word and removes it. A read of 0x20 while the FIFO is empty returns zero.
- R5: An engine pop from an empty transmit FIFO sets status bit 4 (underflow). An engine push into a full receive FIFO sets status bit 5 (overflow), and the word is dropped.
- R6: Writing status with a 1 in a bit position clears that bit, and a 0 leaves the bit unchanged. A condition that is still true sets its bit again on the next cycle.
- R7: Threshold bits [3:0] hold the transmit level and bits [7:4] hold the receive level. Status bit 2 is set when the transmit count is at or below its level. Status bit 3 is set when the receive count is at or above its level.
- R8: A write to 0x08 while status bit 0 (pending) is clear does three things: it pulses `cmd_start` for exactly one cycle, it presents the written word on `cmd_word`, and it sets pending. A write to 0x08 while pending is set produces no strobe and leaves `cmd_word` unchanged.
- R9: `eng_done` clears pending (status bit 0) and sets status bit 1 (done).
- R10: `irq` is high whenever any enabled pair is active. The pairs of enable bit and status bit are: enable 0 with status 1, enable 1 with status 2, enable 2 with status 3, enable 3 with status 4, and enable 4 with status 5.
- R11: Reads of the command offset, the transmit data offset and any unmapped offset return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cfg_word | output | 32 | Configuration word to the engine |
| div_word | output | 16 | Clock divider to the engine |
| cmd_word | output | 32 | Last accepted command |
| cmd_start | output | 1 | One-cycle start strobe |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | 32 | Transmit FIFO head word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Transfer complete pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words and FIFOs 8 deep. With that depth, filling either FIFO takes only eight pushes, so the full-FIFO drop, the overflow, the underflow and both threshold edges are all reached within a few dozen bus cycles. The 8-bit threshold split also allows levels such as 3 and 4 to be programmed. This lets the bench watch the threshold status bits change as words drain or accumulate.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_DIV  = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_THR  = 8'h14;
  localparam logic [7:0] OFS_WCNT = 8'h18;
  localparam logic [7:0] OFS_TXD  = 8'h1C;
  localparam logic [7:0] OFS_RXD  = 8'h20;

  localparam int ST_W    = 6;
  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXTH = 2;
  localparam int ST_RXTH = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;
  localparam int IEN_W   = 5;
  localparam int FLD_W   = 4;
  localparam logic [7:0] THR_RST = 8'h80;
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end
endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status
  import spi_rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] clr_mask,
  input  logic            cmd_acc,
  input  logic            done_ev,
  input  logic            tx_thr,
  input  logic            rx_thr,
  input  logic            tx_unf,
  input  logic            rx_ovf,
  output logic [ST_W-1:0] stat
);
  logic [ST_W-1:0] stat_q, stat_d, set_ev;

  always_comb begin
    set_ev          = '0;
    set_ev[ST_DONE] = done_ev;
    set_ev[ST_TXTH] = tx_thr;
    set_ev[ST_RXTH] = rx_thr;
    set_ev[ST_TXUF] = tx_unf;
    set_ev[ST_RXOF] = rx_ovf;
    stat_d = (stat_q & ~clr_mask) | set_ev;
    stat_d[ST_PEND] = (stat_q[ST_PEND] && !clr_mask[ST_PEND] && !done_ev) || cmd_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_rf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int AW     = 8,
  parameter int DIV_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [31:0]      cfg_word,
  output logic [DIV_W-1:0] div_word,
  output logic [31:0]      cmd_word,
  output logic             cmd_start,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  input  logic             eng_done,
  output logic             irq
);
  logic [31:0]      cfg_q, cfg_d, cmd_q, cmd_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [IEN_W-1:0] ien_q, ien_d;
  logic [7:0]       thr_q, thr_d;
  logic             start_q, start_d;
  logic [ST_W-1:0]  stat, clr_mask;
  logic             cmd_acc, tx_push, rx_pop;
  logic [DW-1:0]    rx_dout;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [FLD_W-1:0] tx_cnt_f, rx_cnt_f;
  logic [7:0]       a8;

  assign a8       = 8'(bus_addr);
  assign tx_push  = bus_wr && (a8 == OFS_TXD);
  assign rx_pop   = bus_rd && (a8 == OFS_RXD);
  assign cmd_acc  = bus_wr && (a8 == OFS_CMD) && !stat[ST_PEND];
  assign clr_mask = (bus_wr && (a8 == OFS_STAT)) ? bus_wdata[ST_W-1:0] : '0;
  assign tx_cnt_f = FLD_W'(tx_cnt);
  assign rx_cnt_f = FLD_W'(rx_cnt);

  spi_rf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(DW'(bus_wdata)),
    .pop(eng_tx_pop), .dout(eng_tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  spi_rf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(eng_rx_push), .din(eng_rx_data),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  spi_rf_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .cmd_acc(cmd_acc),
    .done_ev(eng_done),
    .tx_thr(tx_cnt_f <= thr_q[3:0]),
    .rx_thr(rx_cnt_f >= thr_q[7:4]),
    .tx_unf(eng_tx_pop && tx_empty),
    .rx_ovf(eng_rx_push && rx_full),
    .stat(stat));

  always_comb begin
    cfg_d   = cfg_q;
    div_d   = div_q;
    ien_d   = ien_q;
    thr_d   = thr_q;
    cmd_d   = cmd_q;
    start_d = cmd_acc;
    if (bus_wr) begin
      case (a8)
        OFS_CFG: cfg_d = bus_wdata;
        OFS_DIV: div_d = bus_wdata[DIV_W-1:0];
        OFS_IEN: ien_d = bus_wdata[IEN_W-1:0];
        OFS_THR: thr_d = bus_wdata[7:0];
        default: ;
      endcase
    end
    if (cmd_acc) cmd_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      div_q   <= '0;
      ien_q   <= '0;
      thr_q   <= THR_RST;
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      div_q   <= div_d;
      ien_q   <= ien_d;
      thr_q   <= thr_d;
      cmd_q   <= cmd_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (a8)
        OFS_CFG:  bus_rdata = cfg_q;
        OFS_DIV:  bus_rdata = 32'(div_q);
        OFS_STAT: bus_rdata = 32'(stat);
        OFS_IEN:  bus_rdata = 32'(ien_q);
        OFS_THR:  bus_rdata = 32'(thr_q);
        OFS_WCNT: bus_rdata = 32'({tx_cnt_f, rx_cnt_f});
        OFS_RXD:  bus_rdata = rx_empty ? '0 : 32'(rx_dout);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign cfg_word  = cfg_q;
  assign div_word  = div_q;
  assign cmd_word  = cmd_q;
  assign cmd_start = start_q;
  assign irq       = |(ien_q & stat[ST_W-1:1]);
endmodule

// File: rtl/spi_rf_chk.sv
module spi_rf_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic [5:0]       stat,
  input logic             eng_tx_pop,
  input logic             eng_rx_push,
  input logic             eng_done,
  input logic             tx_empty,
  input logic             rx_full,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [4:0]       ien,
  input logic             irq
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R8
  AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> stat[0]); // R8
  AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH)); // R3
  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH)); // R4
  AST_UNDERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_pop && tx_empty) |=> stat[4]); // R5
  AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_full) |=> stat[5] && rx_full); // R5
  AST_DONE_ENDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && stat[0]) |=> !stat[0] && stat[1]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R10
endmodule

bind spi_regfront spi_rf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .stat(stat),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_done(eng_done),
  .tx_empty(tx_empty), .rx_full(rx_full), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .ien(ien_q), .irq(irq));

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cfg_word, cmd_word, eng_tx_data;
  logic [15:0] div_word;
  logic        cmd_start, irq;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
  logic [31:0] eng_rx_data = '0;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  spi_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_word(cfg_word), .div_word(div_word), .cmd_word(cmd_word),
    .cmd_start(cmd_start), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic eng_pop(string req, logic [31:0] exp);
    @(negedge clk);
    chk(req, eng_tx_data, exp);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(logic [31:0] d);
    @(negedge clk);
    eng_rx_data = d; eng_rx_push = 1'b1;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rdchk("R1 cfg", 8'h00, 32'h0);
    rdchk("R1 div", 8'h04, 32'h0);
    rdchk("R1 ien", 8'h10, 32'h0);
    rdchk("R1 thr", 8'h14, 32'h80);
    rdchk("R1 wcnt", 8'h18, 32'h0);
    rdchk("R1 R7 stat", 8'h0C, 32'h04);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hA5A5_0C13); rdchk("R2 cfg", 8'h00, 32'hA5A5_0C13);
    chk("R2 cfg_word", cfg_word, 32'hA5A5_0C13);
    wr(8'h04, 32'h1234_ABCD); rdchk("R2 div", 8'h04, 32'h0000_ABCD);
    chk("R2 div_word", {16'b0, div_word}, 32'h0000_ABCD);
    wr(8'h10, 32'hFFFF_FFE0); rdchk("R2 ien", 8'h10, 32'h0);
    wr(8'h14, 32'h0000_1234); rdchk("R2 thr", 8'h14, 32'h34);
    wr(8'h14, 32'h80);
    rdchk("R11 cmd read", 8'h08, 32'h0);
    rdchk("R11 txd read", 8'h1C, 32'h0);
    rdchk("R11 unmapped", 8'h24, 32'h0);
    rdchk("R11 wcnt after", 8'h18, 32'h0);
  endtask

  task automatic t_w1c;
    @(negedge clk); eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
    rdchk("R5 underflow", 8'h0C, 32'h14);
    wr(8'h0C, 32'h0); rdchk("R6 zero keeps", 8'h0C, 32'h14);
    wr(8'h0C, 32'h10); rdchk("R6 one clears", 8'h0C, 32'h04);
    wr(8'h0C, 32'h04); rdchk("R6 R7 resets", 8'h0C, 32'h04);
  endtask

  task automatic t_tx;
    for (int i = 0; i < 9; i++) wr(8'h1C, 32'h1111_1111 * (i + 1));
    rdchk("R3 full count", 8'h18, 32'h80);
    wr(8'h14, 32'h83);
    wr(8'h0C, 32'h3F);
    rdchk("R7 tx above level", 8'h0C, 32'h00);
    for (int i = 0; i < 5; i++) eng_pop("R3 order", 32'h1111_1111 * (i + 1));
    rdchk("R3 count 3", 8'h18, 32'h30);
    rdchk("R7 tx at level", 8'h0C, 32'h04);
    for (int i = 5; i < 8; i++) eng_pop("R3 order", 32'h1111_1111 * (i + 1));
    rdchk("R3 drained", 8'h18, 32'h0);
    rdchk("R3 ninth dropped", 8'h0C, 32'h04);
  endtask

  task automatic t_rx;
    wr(8'h14, 32'h40);
    for (int i = 0; i < 3; i++) eng_push(32'hC000_0000 + i);
    wr(8'h0C, 32'h3F);
    rdchk("R7 rx below level", 8'h0C, 32'h04);
    for (int i = 3; i < 9; i++) eng_push(32'hC000_0000 + i);
    rdchk("R4 count", 8'h18, 32'h08);
    rdchk("R5 R7 overflow", 8'h0C, 32'h2C);
    for (int i = 0; i < 8; i++) rdchk("R4 pop order", 8'h20, 32'hC000_0000 + i);
    rdchk("R4 empty read", 8'h20, 32'h0);
    rdchk("R4 empty count", 8'h18, 32'h0);
    wr(8'h14, 32'h80);
  endtask

  task automatic t_cmd;
    wr(8'h0C, 32'h3F);
    wr(8'h08, 32'h001F_0003);
    chk("R8 strobe", {31'b0, cmd_start}, 32'h1);
    chk("R8 word", cmd_word, 32'h001F_0003);
    @(negedge clk);
    chk("R8 one cycle", {31'b0, cmd_start}, 32'h0);
    rdchk("R8 pending", 8'h0C, 32'h05);
    wr(8'h08, 32'h0000_0011);
    chk("R8 ignored strobe", {31'b0, cmd_start}, 32'h0);
    chk("R8 ignored word", cmd_word, 32'h001F_0003);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    rdchk("R9 done", 8'h0C, 32'h06);
  endtask

  task automatic t_irq;
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h01);
    chk("R10 done irq", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h02);
    chk("R10 cleared", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h02);
    chk("R10 tx thr irq", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h10);
    chk("R10 ovf off", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_w1c;
    t_tx;
    t_rx;
    t_cmd;
    t_irq;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule